// File: doc/BRIEF.md
# Receive Holding Queue with Break Injection

This block sits between a serial line receiver and a register read port of a UART channel. Received bytes arrive on a valid/ready handshake and are held in a small first-in first-out store. Register reads pop the oldest byte on a strobe. The block drives two status flags: data-available and queue-full.

A line break is signalled by a separate single-cycle pulse. The pulse raises a sticky break-change flag and pushes a zero byte. The zero byte enters even when the queue is already full; in that case it overwrites the newest entry. A flush input, driven by the receiver-reset command, empties the queue in one cycle. A separate clear pulse, driven by the reset-break-change command, drops the break flag.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty: `rx_avail` and `rx_full` are low, `brk_flag` is low and `rd_data` reads zero.
- R2: `in_ready` is high exactly when `rx_en` is high and `rx_full` is low. A byte is accepted only on a cycle where `in_valid` and `in_ready` are both high.
- R3: Every push sets `rx_avail` from the next cycle. A push that brings the count to DEPTH (four by default) sets `rx_full`.
- R4: `rd_data` always shows the oldest held byte, or zero when empty. A `rd_pop` removes the oldest byte, so bytes come out in arrival order. A pop clears `rx_full`, and it clears `rx_avail` when the count reaches zero.
- R5: A `rd_pop` while empty changes no state, and `rd_data` stays zero.
- R6: A `brk_evt` pulse sets `brk_flag` and pushes a 0x00 byte, whether or not `rx_en` is high. When the queue is full, the 0x00 replaces the newest entry and the count stays at DEPTH.
- R7: `brk_flag` stays high until a `brk_clr` pulse. A `brk_evt` in the same cycle as `brk_clr` wins, so the flag is set.
- R8: `flush` empties the queue and clears `rx_avail` and `rx_full` in one cycle. It has priority over a push, a break push or a pop in the same cycle.
- R9: A normal push and a pop in the same cycle leave the count unchanged and keep the arrival order.
- R10: A break push takes priority over a handshake push in the same cycle; the handshake byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enabled |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Queue can take a byte |
| brk_evt | input | 1 | Line break detected (pulse) |
| brk_clr | input | 1 | Clear break-change flag (pulse) |
| flush | input | 1 | Empty the queue (receiver reset) |
| rd_pop | input | 1 | Read strobe; pops the oldest byte |
| rd_data | output | 8 | Oldest byte, or zero when empty |
| rx_avail | output | 1 | At least one byte held |
| rx_full | output | 1 | DEPTH bytes held |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
The hardest state to reach is a break arriving while the queue is full. Once full, the handshake refuses further bytes, so only `brk_evt` can still write. The bench fills the queue through the handshake and then fires one or several breaks. It pops everything and checks that only the last slot changed. The bench also sweeps every fill level from zero to four against each cycle-level combination of push, pop, break and flush, comparing against a counting model held in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [W-1:0]  wr_val,
    input  logic [PW-1:0] rd_idx,
    output logic [W-1:0]  rd_val
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_val;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rd_val = mem_q[rd_idx];
endmodule

// File: rtl/rxq_brk.sv
module rxq_brk (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R7
    brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              brk_evt,
    input  logic              brk_clr,
    input  logic              flush,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_avail,
    output logic              rx_full,
    output logic              brk_flag
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          wr_en;
    logic [PW-1:0] wr_idx;
    byte_t         wr_val;
    byte_t         mem_out;
    logic          hs_push, do_pop, is_full, is_empty;

    function automatic logic [PW-1:0] wrap(input logic [PW:0] v);
        return (v >= (PW+1)'(DEPTH)) ? PW'(v - (PW+1)'(DEPTH)) : PW'(v);
    endfunction

    assign is_full  = (ctl_q.cnt == FULL_CNT);
    assign is_empty = (ctl_q.cnt == '0);
    assign in_ready = rx_en && !is_full;
    assign hs_push  = in_valid && in_ready && !brk_evt;
    assign do_pop   = rd_pop && !is_empty;

    always_comb begin
        ctl_d  = ctl_q;
        wr_en  = 1'b0;
        wr_idx = '0;
        wr_val = '0;
        if (flush) begin
            ctl_d.head = '0;
            ctl_d.cnt  = '0;
        end else begin
            if (do_pop) begin
                ctl_d.head = wrap({1'b0, ctl_q.head} + 1'b1);
            end
            if (brk_evt) begin
                wr_en  = 1'b1;
                wr_val = '0;
                if (is_full && !do_pop) begin
                    wr_idx = wrap({1'b0, ctl_q.head} + (PW+1)'(DEPTH - 1));
                end else begin
                    wr_idx = wrap({1'b0, ctl_q.head} + (PW+1)'(ctl_q.cnt));
                    if (!do_pop) ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end else if (hs_push) begin
                wr_en  = 1'b1;
                wr_val = in_data;
                wr_idx = wrap({1'b0, ctl_q.head} + (PW+1)'(ctl_q.cnt));
                if (!do_pop) ctl_d.cnt = ctl_q.cnt + 1'b1;
            end else if (do_pop) begin
                ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rxq_store #(.DEPTH(DEPTH), .W(DATA_W)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val),
        .rd_idx (ctl_q.head),
        .rd_val (mem_out)
    );

    rxq_brk brk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (brk_evt),
        .clr_i  (brk_clr),
        .flag_o (brk_flag)
    );

    assign rd_data  = is_empty ? '0 : mem_out;
    assign rx_avail = !is_empty;
    assign rx_full  = is_full;

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rx_avail && !rx_full));
    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_avail && rd_pop && !flush && !brk_evt && !(in_valid && in_ready)) |=> !rx_avail);
    // R6
    brk_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && brk_evt && !flush && !rd_pop) |=> rx_full);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= FULL_CNT);
    // R3
    push_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !flush && !rd_pop) |=> rx_avail);
endmodule

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       rx_en = 0, in_valid = 0, brk_evt = 0, brk_clr = 0, flush = 0, rd_pop = 0;
    logic [7:0] in_data = 0;
    logic       in_ready, rx_avail, rx_full, brk_flag;
    logic [7:0] rd_data;
    int checks = 0, errors = 0;
    logic [7:0] mq[$];
    logic       mbrk = 0;

    always #10 clk = ~clk;

    rxq_top dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk({tag, " R4 data"}, rd_data, mq.size() ? mq[0] : 0);
        chk({tag, " R3 avail"}, rx_avail, mq.size() != 0);
        chk({tag, " R3 full"}, rx_full, mq.size() == 4);
        chk({tag, " R2 ready"}, in_ready, rx_en && mq.size() != 4);
        chk({tag, " R7 brk"}, brk_flag, mbrk);
    endtask

    // drive at negedge, model, step to next negedge, compare
    task automatic step(input logic v, input logic [7:0] d, input logic b, input logic bc,
                        input logic f, input logic p);
        bit acc;
        in_valid = v; in_data = d; brk_evt = b; brk_clr = bc; flush = f; rd_pop = p;
        acc = v && rx_en && mq.size() != 4 && !b;
        if (bc) mbrk = 0;
        if (b) mbrk = 1;
        if (f) mq.delete();
        else begin
            if (p && mq.size()) void'(mq.pop_front());
            if (b) begin
                if (mq.size() == 4) mq[3] = 0; else mq.push_back(0);
            end else if (acc) mq.push_back(d);
        end
        @(negedge clk);
        in_valid = 0; brk_evt = 0; brk_clr = 0; flush = 0; rd_pop = 0;
    endtask

    initial begin
        #3_000_000;
        errors++; checks++;
        $display("FAIL watchdog");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 avail", rx_avail, 0); chk("R1 full", rx_full, 0);
        chk("R1 brk", brk_flag, 0); chk("R1 data", rd_data, 0);
        rst_n = 1; @(negedge clk);
        // R2: disabled receiver refuses
        step(1, 8'h11, 0, 0, 0, 0); compare("R2 disabled");
        rx_en = 1;
        // R3/R4 fill then drain in order
        for (int i = 0; i < 4; i++) begin step(1, 8'hA0 + 8'(i), 0, 0, 0, 0); compare("R3 fill"); end
        step(1, 8'hEE, 0, 0, 0, 0); compare("R2 full refuse");
        // R6 break on full replaces newest, twice
        step(0, 0, 1, 0, 0, 0); compare("R6 full brk");
        step(0, 0, 1, 0, 0, 0); compare("R6 full brk2");
        for (int i = 0; i < 4; i++) begin step(0, 0, 0, 0, 0, 1); compare("R4 drain"); end
        // R5 empty pop
        step(0, 0, 0, 0, 0, 1); compare("R5 empty pop");
        // R7 clear, and set wins over clear
        step(0, 0, 0, 1, 0, 0); compare("R7 clear");
        step(0, 0, 1, 1, 0, 0); compare("R7 set wins");
        step(0, 0, 0, 1, 0, 0); compare("R7 clear2");
        // R6 break while rx disabled
        rx_en = 0; step(0, 0, 1, 0, 0, 0); compare("R6 brk disabled"); rx_en = 1;
        step(0, 0, 0, 0, 1, 0); compare("R8 flush");
        // sweep: every fill level x every combination of v,b,f,p
        for (int lvl = 0; lvl <= 4; lvl++) begin
            for (int c = 0; c < 16; c++) begin
                step(0, 0, 0, 1, 1, 0);
                for (int k = 0; k < lvl; k++) step(1, 8'(lvl * 16 + k + 1), 0, 0, 0, 0);
                step(c[0], 8'(c * 7 + 3), c[1], 0, c[2], c[3]);
                compare(c[2] ? "R8 sweep" : (c[1] ? "R10 sweep" : "R9 sweep"));
                for (int k = 0; k < 5; k++) begin step(0, 0, 0, 0, 0, 1); compare("R9 sweep drain"); end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule